// File: doc/BRIEF.md
# Vertical Interval Line Selector

This block picks one video scan line, or a run of adjacent lines, out of each field. It counts edges on a sampled composite sync stream. Counting starts when a field-start event arms the block. When the count reaches the target, the block raises a gate for the chosen lines. The gate is meant to drive a switch that inserts data into the vertical blanking interval or extracts data from it.

The arming event depends on a two-bit mode:

- **Every field:** the block arms at the end of every vertical sync pulse.
- **Even field only:** the block arms on the falling edge of a field-parity flag.
- **Odd field only:** the block arms on the rising edge of that flag.

On arming, the block loads a down-counter with the requested line number plus two. Every later composite sync edge, rising or falling, decrements the counter. The edge that empties the counter opens the gate. The gate stays open for two sync edges per requested line. When the gate closes, counting stops until the next arming event. All inputs are synchronous to `clk`, and every edge is detected by comparing an input with its value in the previous cycle.

Top module: `vil_line_selector`

## Requirements
- R1: In field modes 2'b00 and 2'b11, a falling edge of `vsync` arms the block. `line_gate` then rises on the clock edge that samples the (`line_sel`+2)-th `csync` transition after arming. Both rising and falling transitions count.
- R2: `line_gate` changes only on a clock edge that samples a `csync` transition or an arming event. At any other clock edge it keeps its value.
- R3: Once open, `line_gate` stays high across 2×`run_len` further `csync` transitions. It falls on the last of them. A `run_len` value of 0 behaves as 1. `run_len` is captured when the block arms.
- R4: After `line_gate` falls, further `csync` transitions never reopen it until the next arming event.
- R5: An arming event with `line_sel` below 3 produces no gate. It also abandons any count or gate already in progress.
- R6: With `line_sel` = 14, the gate opens on the 16th transition after arming.
- R7: In mode 2'b01 (even field), only a falling edge of `field_odd` arms the block. `vsync` and rising edges of `field_odd` are ignored.
- R8: In mode 2'b10 (odd field), only a rising edge of `field_odd` arms the block. `vsync` and falling edges of `field_odd` are ignored.
- R9: A valid arming event while counting or gating restarts the count from the new `line_sel` and drops the gate.
- R10: `line_sel` values up to 2046 work without overflow. With 2046, the gate opens on the 2048th transition.
- R11: While `rst_n` is low and after its release, `line_gate` is low and the block is idle until armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csync | input | 1 | Sampled composite sync level |
| vsync | input | 1 | Vertical sync pulse, active high |
| field_odd | input | 1 | Field parity flag, high during the odd field |
| field_mode | input | 2 | 00/11 every field, 01 even field only, 10 odd field only |
| line_sel | input | LINE_W (11) | Requested line number |
| run_len | input | RUN_W (4) | Number of adjacent lines to gate (0 acts as 1) |
| line_gate | output | 1 | High while the selected lines pass |

## Verification
Some behaviours are checked as properties on every cycle:

- An arming event leaves the block counting with the gate closed, or idle when `line_sel` is invalid.
- The gate opens only out of the counting state, on a sync edge.
- A closing gate never leaves counting active.
- Nothing changes in a cycle without a sync edge or an arming event.

Other behaviours only the bench's scenarios can show: the exact transition number at which the gate opens, its length in transitions, field qualification per mode, restart and abort, and the full-range line value.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_GATE  = 2'd2
    } phase_t;

    localparam logic [1:0] MODE_EVERY = 2'b00;
    localparam logic [1:0] MODE_EVEN  = 2'b01;
    localparam logic [1:0] MODE_ODD   = 2'b10;

    localparam int MIN_LINE = 3;

endpackage

// File: rtl/lsel_edge.sv
module lsel_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = sig[i] & ~prev_q[i];
        assign fall[i] = ~sig[i] & prev_q[i];
    end
endmodule

// File: rtl/lsel_qual.sv
module lsel_qual
    import lsel_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       vs_fall,
    input  logic       fld_rise,
    input  logic       fld_fall,
    output logic       load
);
    always_comb begin
        case (mode)
            MODE_EVEN: load = fld_fall;
            MODE_ODD:  load = fld_rise;
            default:   load = vs_fall;
        endcase
    end
endmodule

// File: rtl/lsel_core.sv
module lsel_core
    import lsel_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int RUN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LINE_W-1:0] line_sel,
    input  logic [RUN_W-1:0]  run_len,
    output logic              gate,
    output logic              counting
);
    localparam int CNT_W = ((LINE_W > RUN_W) ? LINE_W : RUN_W) + 1;

    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
        logic [RUN_W-1:0] run;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            if (int'(line_sel) >= MIN_LINE) begin
                st_d.phase = PH_COUNT;
                st_d.cnt   = CNT_W'(line_sel) + CNT_W'(2);
                st_d.run   = (run_len == '0) ? RUN_W'(1) : run_len;
            end else begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        end else if (step) begin
            case (st_q.phase)
                PH_COUNT: begin
                    if (st_q.cnt == CNT_W'(1)) begin
                        st_d.phase = PH_GATE;
                        st_d.cnt   = CNT_W'({st_q.run, 1'b0});
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                    end
                end
                PH_GATE: begin
                    if (st_q.cnt == CNT_W'(1)) begin
                        st_d.phase = PH_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.run   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate     = (st_q.phase == PH_GATE);
    assign counting = (st_q.phase == PH_COUNT);
endmodule

// File: rtl/vil_line_selector.sv
module vil_line_selector #(
    parameter int LINE_W = 11,
    parameter int RUN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csync,
    input  logic              vsync,
    input  logic              field_odd,
    input  logic [1:0]        field_mode,
    input  logic [LINE_W-1:0] line_sel,
    input  logic [RUN_W-1:0]  run_len,
    output logic              line_gate
);
    logic [2:0] ev_rise, ev_fall;
    logic       sync_step;
    logic       load_pulse;
    logic       counting;

    lsel_edge #(.N(3)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({field_odd, vsync, csync}),
        .rise  (ev_rise),
        .fall  (ev_fall)
    );

    assign sync_step = ev_rise[0] | ev_fall[0];

    lsel_qual u_qual (
        .mode     (field_mode),
        .vs_fall  (ev_fall[1]),
        .fld_rise (ev_rise[2]),
        .fld_fall (ev_fall[2]),
        .load     (load_pulse)
    );

    lsel_core #(.LINE_W(LINE_W), .RUN_W(RUN_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_pulse),
        .step     (sync_step),
        .line_sel (line_sel),
        .run_len  (run_len),
        .gate     (line_gate),
        .counting (counting)
    );
endmodule

// File: rtl/vil_line_selector_chk.sv
module vil_line_selector_chk #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_pulse,
    input logic              sync_step,
    input logic [LINE_W-1:0] line_sel,
    input logic              counting,
    input logic              line_gate
);
    // R5: an invalid line value leaves the block idle
    a_r5_invalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && int'(line_sel) < 3) |=> (!counting && !line_gate));

    // R9 / R1: a valid arm always restarts counting with the gate closed
    a_r9_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && int'(line_sel) >= 3) |=> (counting && !line_gate));

    // R1: the gate opens only from counting, on a sync edge
    a_r1_open_from_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_gate) |-> $past(counting && sync_step && !load_pulse));

    // R4: closing the gate does not leave counting active
    a_r4_close_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(line_gate) && !$past(load_pulse)) |-> !counting);

    // R2: nothing moves without a sync edge or arm
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_pulse && !sync_step) |=> ($stable(line_gate) && $stable(counting)));
endmodule

bind vil_line_selector vil_line_selector_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_pulse (load_pulse),
    .sync_step  (sync_step),
    .line_sel   (line_sel),
    .counting   (counting),
    .line_gate  (line_gate)
);

// File: tb/vil_line_selector_test.sv
module vil_line_selector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csync = 1'b0;
    logic        vsync = 1'b0;
    logic        field_odd = 1'b0;
    logic [1:0]  field_mode = 2'b00;
    logic [10:0] line_sel = '0;
    logic [3:0]  run_len = '0;
    logic        line_gate;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    vil_line_selector uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .csync      (csync),
        .vsync      (vsync),
        .field_odd  (field_odd),
        .field_mode (field_mode),
        .line_sel   (line_sel),
        .run_len    (run_len),
        .line_gate  (line_gate)
    );

    // table: mode, line, run, event (0 vsync, 1 flag fall, 2 flag rise), expected open, expected length
    localparam int NV = 13;
    localparam int T_MODE[NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 2, 2, 1, 0, 3};
    localparam int T_SEL [NV] = '{14, 3, 20, 2, 0, 5, 10, 10, 8, 8, 6, 6, 4};
    localparam int T_RUN [NV] = '{1, 1, 3, 1, 1, 0, 1, 1, 2, 2, 1, 1, 1};
    localparam int T_EV  [NV] = '{0, 0, 0, 0, 0, 0, 1, 2, 2, 1, 0, 1, 0};
    localparam int T_OPEN[NV] = '{16, 5, 22, 0, 0, 7, 12, 0, 10, 0, 0, 0, 6};
    localparam int T_LEN [NV] = '{2, 2, 6, 0, 0, 2, 2, 0, 4, 0, 0, 0, 2};
    localparam string T_REQ[NV] = '{"R6", "R1", "R3", "R5", "R5", "R3", "R7", "R7",
                                    "R8", "R8", "R7", "R1", "R1"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input int ev);
        if (ev == 0) begin
            vsync = 1'b1; @(negedge clk);
            vsync = 1'b0; @(negedge clk);
        end else begin
            field_odd = ~field_odd; @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic prep(input int mode, input int sel, input int rl, input int ev);
        field_mode = 2'b00;
        if (ev == 1) field_odd = 1'b1;
        if (ev == 2) field_odd = 1'b0;
        @(negedge clk); @(negedge clk);
        field_mode = 2'(mode);
        line_sel   = 11'(sel);
        run_len    = 4'(rl);
        @(negedge clk);
    endtask

    // apply n transitions; report first index with gate high and total high count
    task automatic steps(input int n, output int open_at, output int hi_len);
        open_at = 0;
        hi_len  = 0;
        for (int k = 1; k <= n; k++) begin
            csync = ~csync;
            @(negedge clk);
            if (line_gate) begin
                if (open_at == 0) open_at = k;
                hi_len++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int op, ln;
        // R11: reset holds the gate low, even with sync activity
        repeat (3) @(negedge clk);
        csync = 1'b1; @(negedge clk);
        check(line_gate == 1'b0, "R11 in reset", int'(line_gate), 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check(line_gate == 1'b0, "R11 after reset", int'(line_gate), 0);
        steps(30, op, ln);
        check(op == 0, "R11 idle until armed", op, 0);

        for (int i = 0; i < NV; i++) begin
            prep(T_MODE[i], T_SEL[i], T_RUN[i], T_EV[i]);
            fire(T_EV[i]);
            steps(40, op, ln);
            check(op == T_OPEN[i], T_REQ[i], op, T_OPEN[i]);
            check(ln == T_LEN[i], (T_LEN[i] == 0) ? "R4" : "R3", ln, T_LEN[i]);
        end

        // R9: rearm mid-count restarts from the new arm
        prep(0, 10, 1, 0);
        fire(0);
        steps(5, op, ln);
        check(op == 0, "R9 before rearm", op, 0);
        fire(0);
        steps(40, op, ln);
        check(op == 12, "R9 restart open", op, 12);
        check(ln == 2, "R9 restart length", ln, 2);

        // R9: rearm while the gate is open drops it at once
        prep(0, 3, 4, 0);
        fire(0);
        steps(6, op, ln);
        check(line_gate == 1'b1, "R9 gate open", int'(line_gate), 1);
        line_sel = 11'd7;
        vsync = 1'b1; @(negedge clk);
        vsync = 1'b0; @(negedge clk);
        check(line_gate == 1'b0, "R9 gate dropped", int'(line_gate), 0);
        @(negedge clk);
        steps(40, op, ln);
        check(op == 9, "R9 reopen", op, 9);

        // R5: invalid arm abandons a count in progress
        prep(0, 10, 1, 0);
        fire(0);
        steps(5, op, ln);
        line_sel = 11'd1;
        fire(0);
        steps(40, op, ln);
        check(op == 0, "R5 abort", op, 0);

        // R10: largest line value
        prep(0, 2046, 1, 0);
        fire(0);
        steps(2050, op, ln);
        check(op == 2048, "R10 open", op, 2048);
        check(ln == 2, "R10 length", ln, 2);

        // R2: quiet cycles keep the gate unchanged
        prep(0, 3, 1, 0);
        fire(0);
        steps(5, op, ln);
        repeat (10) @(negedge clk);
        check(line_gate == 1'b1, "R2 hold", int'(line_gate), 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule